// File: doc/BRIEF.md
# Multiplexed Bus Master Sequencer

This block is the bus-master state machine that carries single and burst read/write transfers onto a host bus. On that bus, address and data share one set of AD lines. The requester hands over one command: start address, size code, direction, addressing mode and write data. The sequencer then runs the bus handshake on its own.

It raises a bus request and waits for the grant. It then presents the address and runs one or more data beats. A beat is stretched with wait states until the slave acknowledges. The sequencer then spends one recovery clock releasing the bus. Read data comes back beat by beat, and a done pulse carries an error flag.

There are two addressing modes. In physical mode the sequencer drives the address itself. In virtual mode it presents a virtual address for one clock. It then leaves the AD lines free for one translation clock and for a clock in which the host puts the translated address on them. A configuration input chooses when address strobe drops during a burst.

Top module: `mbm_sequencer`

## Requirements
- R1: While a command waits for the grant, `bus_br` is high and `bus_as` and `bus_addr_oe` stay low for as many clocks as the grant is withheld.
- R2: The sequencer leaves the request phase on the first clock edge at which `bus_bg` is seen high. The address phase (or virtual-address phase) is therefore visible in the very next clock, well inside the three-clock limit.
- R3: In the physical address phase the sequencer drives the following:
  - `bus_as` high.
  - The start address on both `bus_addr` and `bus_ad_out`, with `bus_ad_oe` high.
  - `bus_rw` = 1 for read and 0 for write.
  - `bus_siz` = the command's size code.
  - `bus_br` equal to `more_pending`.
- R4: Each data clock has `bus_den` high, and the beat is held with an unchanged `bus_addr` until `bus_ack` is sampled high. For a read, the AD input at the acknowledged edge appears on `rd_data`, with `rd_valid` high, one clock later.
- R5: Size codes are 0 byte, 1 halfword, 2 word, 3 burst of 4 beats, 4 burst of 8 beats (5 to 7 act as a single beat). During bursts `bus_addr` advances by BUS_W/8 after each acknowledged beat.
- R6: During a burst with `cfg_as_early` = 0, `bus_as` stays high in every data beat except the last. With `cfg_as_early` = 1 it is low from the first data clock.
- R7: For a single transfer `bus_as` is low throughout the data phase.
- R8: The recovery clock shows `done` high with `bus_as`, `bus_rw`, `bus_den`, `bus_siz`, `bus_ad_oe` and `bus_addr_oe` all low. The next clock returns to idle with `req_ready` high.
- R9: In virtual mode there are three clocks between the grant and the data phase:
  - a virtual-address clock with `bus_as` low and the address driven on AD;
  - a translation clock with AD released;
  - a host-address clock with AD released and `bus_as` high.
- R10: During read data beats `bus_ad_oe` is low. During write data beats `bus_ad_oe` is high and `bus_ad_out` carries `req_wdata`.
- R11: A beat acknowledged with `bus_err` high is the last beat. The sequencer goes to recovery, returns no read data for that beat, and raises `done_err` together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present (taken when `req_ready`) |
| req_ready | output | 1 | Sequencer idle, command accepted |
| req_addr | input | BUS_W | Start address |
| req_size | input | 3 | Size code (see R5) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_virt | input | 1 | 1 = virtual addressing mode |
| req_wdata | input | BUS_W | Write data for the current beat |
| more_pending | input | 1 | Another transfer follows; keeps bus request high |
| cfg_as_early | input | 1 | Burst strobe drop point: 1 first data clock, 0 last |
| rd_data | output | BUS_W | Captured read data |
| rd_valid | output | 1 | `rd_data` valid for one clock |
| done | output | 1 | Transfer finished (recovery clock) |
| done_err | output | 1 | Transfer ended by an error |
| bus_br | output | 1 | Bus request |
| bus_bg | input | 1 | Bus grant |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_siz | output | 3 | Size code on the bus |
| bus_den | output | 1 | Data enable |
| bus_addr | output | BUS_W | Address lines |
| bus_addr_oe | output | 1 | Address line drive enable |
| bus_ad_out | output | BUS_W | Multiplexed AD output value |
| bus_ad_oe | output | 1 | AD output enable |
| bus_ad_in | input | BUS_W | Multiplexed AD input value |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error, valid with acknowledge |

## Verification
The bench builds the sequencer with its default BUS_W of 32, so every burst beat steps the address by four bytes. An eight-beat burst therefore reaches offset 0x1C. That lets the slave model check each beat's address against a simple sum. Transfers are run in both addressing modes, with both strobe-drop settings, with zero to three wait states per beat and with grants delayed up to three clocks. Errors are injected on first and middle beats. A queue of expected read words is compared in order against `rd_data` as it appears.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_VADDR,
        ST_XLATE,
        ST_HPA,
        ST_DATA,
        ST_RCV
    } mbm_state_e;

    localparam logic [2:0] SZ_BYTE   = 3'd0;
    localparam logic [2:0] SZ_HALF   = 3'd1;
    localparam logic [2:0] SZ_WORD   = 3'd2;
    localparam logic [2:0] SZ_BURST4 = 3'd3;
    localparam logic [2:0] SZ_BURST8 = 3'd4;

    localparam int BEAT_CNT_W = 4;

    typedef struct packed {
        logic [2:0] size;
        logic       write;
        logic       virt;
    } mbm_cmd_t;

    function automatic logic [BEAT_CNT_W-1:0] beats_of(input logic [2:0] sz);
        case (sz)
            SZ_BURST4: return BEAT_CNT_W'(4);
            SZ_BURST8: return BEAT_CNT_W'(8);
            default:   return BEAT_CNT_W'(1);
        endcase
    endfunction

    function automatic logic is_burst(input logic [2:0] sz);
        return (sz == SZ_BURST4) || (sz == SZ_BURST8);
    endfunction

endpackage

// File: rtl/mbm_beat_ctr.sv
module mbm_beat_ctr
    import mbm_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [BUS_W-1:0]      base,
    input  logic [BEAT_CNT_W-1:0] total,
    input  logic                  advance,
    output logic [BUS_W-1:0]      beat_addr,
    output logic                  last
);
    localparam int STEP = BUS_W / 8;

    logic [BEAT_CNT_W-1:0] cnt_q;
    logic [BEAT_CNT_W-1:0] total_q;
    logic [BUS_W-1:0]      addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            total_q <= BEAT_CNT_W'(1);
            addr_q  <= '0;
        end else if (load) begin
            cnt_q   <= '0;
            total_q <= total;
            addr_q  <= base;
        end else if (advance) begin
            cnt_q   <= cnt_q + BEAT_CNT_W'(1);
            addr_q  <= addr_q + BUS_W'(STEP);
        end
    end

    assign beat_addr = addr_q;
    assign last      = (cnt_q == (total_q - BEAT_CNT_W'(1)));

endmodule

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
    import mbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       virt,
    input  logic       bus_bg,
    input  logic       bus_ack,
    input  logic       bus_err,
    input  logic       last,
    output mbm_state_e state,
    output logic       load,
    output logic       advance,
    output logic       err_flag
);
    mbm_state_e state_q, state_d;
    logic       err_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_REQ;
            ST_REQ:   if (bus_bg) state_d = virt ? ST_VADDR : ST_ADDR;
            ST_ADDR:  state_d = ST_DATA;
            ST_VADDR: state_d = ST_XLATE;
            ST_XLATE: state_d = ST_HPA;
            ST_HPA:   state_d = ST_DATA;
            ST_DATA:  if (bus_ack && (bus_err || last)) state_d = ST_RCV;
            ST_RCV:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign load    = (state_q == ST_IDLE) && req_valid;
    assign advance = (state_q == ST_DATA) && bus_ack && !bus_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                err_q <= 1'b0;
            end else if ((state_q == ST_DATA) && bus_ack && bus_err) begin
                err_q <= 1'b1;
            end
        end
    end

    assign state    = state_q;
    assign err_flag = err_q;

endmodule

// File: rtl/mbm_sequencer.sv
module mbm_sequencer
    import mbm_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [2:0]       req_size,
    input  logic             req_write,
    input  logic             req_virt,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic             more_pending,
    input  logic             cfg_as_early,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             done_err,
    output logic             bus_br,
    input  logic             bus_bg,
    output logic             bus_as,
    output logic             bus_rw,
    output logic [2:0]       bus_siz,
    output logic             bus_den,
    output logic [BUS_W-1:0] bus_addr,
    output logic             bus_addr_oe,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [BUS_W-1:0] bus_ad_in,
    input  logic             bus_ack,
    input  logic             bus_err
);
    mbm_state_e       state;
    logic             load, advance, err_flag, last;
    logic [BUS_W-1:0] beat_addr;
    mbm_cmd_t         cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= '{size: req_size, write: req_write, virt: req_virt};
        end
    end

    mbm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .virt      (cmd_q.virt),
        .bus_bg    (bus_bg),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .last      (last),
        .state     (state),
        .load      (load),
        .advance   (advance),
        .err_flag  (err_flag)
    );

    mbm_beat_ctr #(.BUS_W(BUS_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .base      (req_addr),
        .total     (beats_of(req_size)),
        .advance   (advance),
        .beat_addr (beat_addr),
        .last      (last)
    );

    // read capture, one clock after the acknowledged edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= advance && !cmd_q.write;
            if (advance && !cmd_q.write) begin
                rd_data <= bus_ad_in;
            end
        end
    end

    logic in_xfer;
    assign in_xfer = (state == ST_ADDR) || (state == ST_VADDR) || (state == ST_XLATE) ||
                     (state == ST_HPA)  || (state == ST_DATA);

    always_comb begin
        bus_br      = 1'b0;
        bus_as      = 1'b0;
        bus_den     = 1'b0;
        bus_ad_oe   = 1'b0;
        bus_ad_out  = '0;
        bus_rw      = in_xfer && !cmd_q.write;
        bus_siz     = in_xfer ? cmd_q.size : 3'd0;
        bus_addr_oe = in_xfer;
        bus_addr    = in_xfer ? beat_addr : '0;
        done        = 1'b0;
        done_err    = 1'b0;
        case (state)
            ST_REQ: bus_br = 1'b1;
            ST_ADDR: begin
                bus_br     = more_pending;
                bus_as     = 1'b1;
                bus_ad_oe  = 1'b1;
                bus_ad_out = beat_addr;
            end
            ST_VADDR: begin
                bus_br     = more_pending;
                bus_ad_oe  = 1'b1;
                bus_ad_out = beat_addr;
            end
            ST_HPA: bus_as = 1'b1;
            ST_DATA: begin
                bus_den    = 1'b1;
                bus_as     = is_burst(cmd_q.size) && !cfg_as_early && !last;
                bus_ad_oe  = cmd_q.write;
                bus_ad_out = cmd_q.write ? req_wdata : '0;
            end
            ST_RCV: begin
                done     = 1'b1;
                done_err = err_flag;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/mbm_sequencer_chk.sv
module mbm_sequencer_chk
    import mbm_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input mbm_state_e       state,
    input logic             bus_bg,
    input logic             bus_as,
    input logic             bus_rw,
    input logic [2:0]       bus_siz,
    input logic             bus_den,
    input logic [BUS_W-1:0] bus_addr,
    input logic             bus_addr_oe,
    input logic             bus_ad_oe,
    input logic             bus_ack,
    input logic             bus_err,
    input logic             done,
    input logic             done_err
);
    localparam int STEP = BUS_W / 8;

    // R2
    grant_to_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && bus_bg) |=> (state == ST_ADDR || state == ST_VADDR));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_den && !bus_ack) |=> (bus_den && $stable(bus_addr)));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_den && bus_ack && !bus_err) |=> (!bus_den || bus_addr == $past(bus_addr) + BUS_W'(STEP)));

    // R10
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_den && bus_rw) |-> !bus_ad_oe);

    // R8
    recovery_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_as && !bus_rw && !bus_den && bus_siz == 3'd0 && !bus_ad_oe && !bus_addr_oe));

    // R11
    err_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_den && bus_ack && bus_err) |=> (done && done_err));

    // R9
    xlate_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VADDR) |=> (!bus_ad_oe && !bus_as));

endmodule

bind mbm_sequencer mbm_sequencer_chk #(.BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .bus_bg      (bus_bg),
    .bus_as      (bus_as),
    .bus_rw      (bus_rw),
    .bus_siz     (bus_siz),
    .bus_den     (bus_den),
    .bus_addr    (bus_addr),
    .bus_addr_oe (bus_addr_oe),
    .bus_ad_oe   (bus_ad_oe),
    .bus_ack     (bus_ack),
    .bus_err     (bus_err),
    .done        (done),
    .done_err    (done_err)
);

// File: tb/tb_mbm_sequencer.sv
`timescale 1ns/1ps
module tb_mbm_sequencer;
    localparam int W    = 32;
    localparam int STEP = W / 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [W-1:0] req_addr = '0;
    logic [2:0]   req_size = 3'd0;
    logic         req_write = 1'b0;
    logic         req_virt = 1'b0;
    logic [W-1:0] req_wdata;
    logic         more_pending = 1'b0;
    logic         cfg_as_early = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid, done, done_err;
    logic         bus_br, bus_as, bus_rw, bus_den, bus_addr_oe, bus_ad_oe;
    logic         bus_bg = 1'b0;
    logic [2:0]   bus_siz;
    logic [W-1:0] bus_addr, bus_ad_out;
    logic [W-1:0] bus_ad_in = '0;
    logic         bus_ack = 1'b0;
    logic         bus_err = 1'b0;

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // slave model state
    int           wait_n = 0;
    int           err_at = -1;
    int           beat = 0;
    int           wcnt = 0;
    logic [W-1:0] base = '0;
    bit           exp_write = 1'b0;
    bit           as_rec [8];
    bit           rv_exp = 1'b0;
    logic [W-1:0] rq [$];

    function automatic logic [W-1:0] rpat(input logic [W-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [W-1:0] wpat(input int k);
        return 32'hC0DE_0000 + W'(k);
    endfunction

    assign req_wdata = wpat(beat);

    mbm_sequencer #(.BUS_W(W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_virt(req_virt), .req_wdata(req_wdata), .more_pending(more_pending),
        .cfg_as_early(cfg_as_early), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .done_err(done_err), .bus_br(bus_br), .bus_bg(bus_bg),
        .bus_as(bus_as), .bus_rw(bus_rw), .bus_siz(bus_siz), .bus_den(bus_den),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ack(bus_ack),
        .bus_err(bus_err)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // slave, read-timing and write-data checks
    always @(negedge clk) begin
        // R4: rd_valid follows an acknowledged read beat by one clock
        chk(rd_valid == rv_exp, "R4 rd_valid timing", W'(rd_valid), W'(rv_exp));
        rv_exp  = 1'b0;
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (bus_den && !rst) begin
            chk(bus_addr == base + W'(beat * STEP), "R5 beat address", bus_addr,
                base + W'(beat * STEP));
            chk(bus_ad_oe == exp_write, "R10 AD drive in data", W'(bus_ad_oe), W'(exp_write));
            if (beat < 8) as_rec[beat] = bus_as;
            if (wcnt == wait_n) begin
                bus_ack = 1'b1;
                bus_err = (beat == err_at);
                if (exp_write) begin
                    chk(bus_ad_out == wpat(beat), "R10 write data", bus_ad_out, wpat(beat));
                end else begin
                    bus_ad_in = rpat(bus_addr);
                    rv_exp    = !bus_err;
                end
                wcnt = 0;
                beat++;
            end else begin
                wcnt++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_valid) begin
            if (rq.size() == 0) begin
                chk(1'b0, "R4 unexpected read data", rd_data, '0);
            end else begin
                logic [W-1:0] e;
                e = rq.pop_front();
                chk(rd_data == e, "R4 read data", rd_data, e);
            end
        end
    end

    task automatic run(input logic [W-1:0] addr, input logic [2:0] size, input bit wr,
                       input bit virt, input bit early, input bit more, input int gdly,
                       input int waits, input int errat);
        int  nb;
        int  exp_beats;
        bit  burst;
        nb    = (size == 3'd3) ? 4 : (size == 3'd4) ? 8 : 1;
        burst = (nb > 1);
        exp_beats = (errat >= 0 && errat < nb) ? errat + 1 : nb;
        @(negedge clk);
        base = addr; beat = 0; wcnt = 0; wait_n = waits; err_at = errat; exp_write = wr;
        for (int k = 0; k < 8; k++) as_rec[k] = 1'b0;
        req_valid = 1'b1; req_addr = addr; req_size = size; req_write = wr;
        req_virt = virt; cfg_as_early = early; more_pending = more;
        if (!wr) begin
            for (int k = 0; k < nb; k++) begin
                if (errat < 0 || k < errat) rq.push_back(rpat(addr + W'(k * STEP)));
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_br && !bus_as, "R1 request raised", W'(bus_br), 1);
        for (int g = 0; g < gdly; g++) begin
            @(negedge clk);
            chk(bus_br && !bus_as && !bus_addr_oe, "R1 wait for grant", W'(bus_as), 0);
        end
        bus_bg = 1'b1;
        @(negedge clk);
        bus_bg = 1'b0;
        if (!virt) begin
            chk(bus_as, "R2 address phase next clock", W'(bus_as), 1);
            chk(bus_addr == addr && bus_addr_oe, "R3 address lines", bus_addr, addr);
            chk(bus_ad_oe && bus_ad_out == addr, "R3 AD address", bus_ad_out, addr);
            chk(bus_rw == !wr && bus_siz == size, "R3 rw/size", {bus_rw, bus_siz},
                {!wr, size});
            chk(bus_br == more, "R3 request drop", W'(bus_br), W'(more));
        end else begin
            chk(!bus_as && bus_ad_oe && bus_ad_out == addr, "R9 virtual address clock",
                bus_ad_out, addr);
            @(negedge clk);
            chk(!bus_ad_oe && !bus_den, "R9 translation clock", W'(bus_ad_oe), 0);
            @(negedge clk);
            chk(!bus_ad_oe && bus_as && !bus_den, "R9 host address clock", W'(bus_as), 1);
        end
        for (int t = 0; t < 200 && !done; t++) @(negedge clk);
        chk(done, "R8 done", W'(done), 1);
        chk(!bus_as && !bus_rw && !bus_den && bus_siz == 0 && !bus_ad_oe && !bus_addr_oe,
            "R8 recovery quiet", {bus_as, bus_rw, bus_den, bus_ad_oe, bus_addr_oe}, 0);
        chk(done_err == (errat >= 0 && errat < nb), "R11 error flag", W'(done_err),
            W'(errat >= 0 && errat < nb));
        chk(beat == exp_beats, "R5 R11 beat count", W'(beat), W'(exp_beats));
        if (exp_beats == nb) begin
            for (int k = 0; k < nb; k++) begin
                bit ea;
                ea = burst && !early && (k != nb - 1);
                chk(as_rec[k] == ea, burst ? "R6 burst strobe" : "R7 single strobe",
                    W'(as_rec[k]), W'(ea));
            end
        end
        @(negedge clk);
        chk(req_ready && !done, "R8 back to idle", W'(req_ready), 1);
        chk(rq.size() == 0, "R4 R11 read queue drained", W'(rq.size()), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_br && !bus_as && !bus_ad_oe && !done && !bus_den,
            "R8 reset state", {req_ready, bus_br, bus_as, bus_ad_oe, done}, 5'b10000);
        run(32'h0000_1000, 3'd2, 0, 0, 0, 0, 2, 0, -1);
        run(32'h0000_2003, 3'd0, 1, 0, 0, 1, 0, 2, -1);
        run(32'h0000_3000, 3'd3, 0, 0, 0, 0, 1, 1, -1);
        run(32'h0000_4000, 3'd4, 1, 0, 1, 0, 3, 0, -1);
        run(32'h0000_5000, 3'd4, 0, 0, 0, 1, 0, 0, -1);
        run(32'h8000_6000, 3'd1, 0, 1, 0, 0, 1, 1, -1);
        run(32'h8000_7000, 3'd3, 1, 1, 1, 0, 0, 1, -1);
        run(32'h0000_8000, 3'd3, 0, 0, 0, 0, 1, 0, 2);
        run(32'h0000_9000, 3'd2, 1, 0, 0, 0, 0, 1, 0);
        run(32'h0000_A000, 3'd4, 1, 0, 0, 0, 2, 3, -1);
        run(32'h8000_B000, 3'd4, 0, 1, 0, 0, 0, 0, -1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule